// File: doc/BRIEF.md
# Disk Bus Access Arbiter

This block decides who may use a disk-interface cycle engine. There are two kinds of user. The first is the host, which makes register reads and writes as programmed-I/O. The second is a buffered DMA transfer that the drive requests. One engine runs one bus cycle at a time. Its length is fixed by the kind of cycle:

- a programmed-I/O cycle,
- a multiword DMA cycle,
- an ultra DMA cycle.

A cycle that has started always runs to its end. Between cycles the arbiter chooses the next owner. A host request always wins that choice.

The host side uses a request/ready handshake. The host raises `host_req` and holds its address, direction and write data steady. It waits, stalled, until `host_rdy` pulses. No data is buffered for programmed-I/O. Read data comes straight from the disk bus in the cycle that `host_rdy` is high, and the data buffer is left untouched.

The DMA side works as follows:

- Software loads a word count.
- DMA is enabled and a direction is chosen.
- While the drive holds its request line high, the block runs one DMA cycle per word.
- It pauses when the buffer cannot take or give a word.
- It pauses while the host owns the bus.
- It pauses while the drive drops its request.
- The remaining count is kept across every pause.
- A done pulse marks the final word.

Top module: `disk_arb_top`

## Requirements
- R1: During reset and after its release, with no count loaded: `host_rdy`, `disk_cyc`, `xfer_done`, `buf_push` and `buf_pop` are 0, and `disk_kind` is 0. Holding `dma_en` and `drq` high with no count loaded starts no cycle.
- R2: If `host_req` rises while the engine is idle, `disk_cyc` is high from the next cycle for exactly LAT_PIO cycles. `host_rdy` is high for one cycle, the last of those cycles, and `host_rdata` equals `disk_rdata` in that cycle.
- R3: During a programmed-I/O cycle, `disk_kind` = 2'b01 and `disk_addr`/`disk_we`/`disk_wdata` mirror `host_addr`/`host_we`/`host_wdata`. `buf_push` and `buf_pop` stay 0.
- R4: A DMA cycle starts only while `dma_en` = 1, `drq` = 1 and the remaining count is nonzero.
- R5: A DMA cycle has `disk_kind` = 2'b11 and lasts LAT_UD cycles when `udma_sel` = 1. When `udma_sel` = 0 it has `disk_kind` = 2'b10 and lasts LAT_MW cycles. `disk_kind` holds for the whole cycle.
- R6: When a host request and a DMA request are both pending with the engine idle, the programmed-I/O cycle goes first. A DMA cycle in progress is never cut short. After the host cycle, DMA resumes and the total word count is preserved.
- R7: When `dma_dir` = 0 (disk to buffer), no DMA cycle starts while `buf_full` = 1. When `dma_dir` = 1 (buffer to disk), no DMA cycle starts while `buf_empty` = 1. DMA continues when the flag clears.
- R8: Each DMA cycle ends with one single-cycle pulse in its last cycle: `buf_pop` if `dma_dir` = 1, `buf_push` if `dma_dir` = 0. The pulse decrements the remaining count, so a transfer loaded with N gives exactly N pulses. When `dma_dir` = 1, `disk_wdata` equals `buf_rdata`.
- R9: `xfer_done` pulses once, together with the final word's pulse. No further DMA cycle starts until a new count is loaded.
- R10: If `drq` falls, no new DMA cycle starts, but the remaining count is kept. When `drq` rises again, the transfer completes with the original total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Host programmed-I/O request, held until ready |
| host_we | input | 1 | Host access is a write |
| host_addr | input | AW | Disk register address |
| host_wdata | input | DW | Host write data |
| host_rdy | output | 1 | Programmed-I/O cycle completes this cycle |
| host_rdata | output | DW | Read data, valid with host_rdy |
| dma_en | input | 1 | DMA acceptance enable |
| udma_sel | input | 1 | 1 = ultra DMA cycles, 0 = multiword |
| dma_dir | input | 1 | 1 = buffer to disk, 0 = disk to buffer |
| drq | input | 1 | Drive DMA request |
| xfer_load | input | 1 | Load xfer_len into the remaining count |
| xfer_len | input | CNTW | Words in the transfer |
| xfer_done | output | 1 | Final word of the transfer completes |
| buf_full | input | 1 | Buffer cannot accept a word |
| buf_empty | input | 1 | Buffer holds no word |
| buf_rdata | input | DW | Buffer head word for disk writes |
| buf_push | output | 1 | Store disk_rdata into the buffer |
| buf_pop | output | 1 | Head word consumed by the disk |
| disk_cyc | output | 1 | Bus cycle in progress |
| disk_kind | output | 2 | 01 PIO, 10 multiword, 11 ultra, 00 idle |
| disk_we | output | 1 | Cycle writes the disk |
| disk_addr | output | AW | Register address (0 for DMA) |
| disk_wdata | output | DW | Data driven to the disk |
| disk_rdata | input | DW | Data returned by the disk |

## Verification
Each kind of internal fault shows up at the ports:

- A wrong engine countdown shows in the first cycle as a bus cycle whose length in clocks does not match its kind. It is caught as soon as `disk_cyc` falls.
- A lost or doubled decrement of the remaining count shows as a transfer with the wrong number of buffer pulses, or with `xfer_done` on the wrong word. It is seen when the transfer ends or stalls.
- A wrong priority decision shows in the cycle after a simultaneous request, as `disk_kind` not being programmed-I/O.
- Broken pause logic shows as bus cycles appearing while a buffer flag is set or while `drq` is low.

// File: rtl/disk_arb_pkg.sv
package disk_arb_pkg;
  typedef enum logic [1:0] {
    KIND_NONE = 2'b00,
    KIND_PIO  = 2'b01,
    KIND_MW   = 2'b10,
    KIND_UD   = 2'b11
  } cyc_kind_e;
endpackage

// File: rtl/disk_arb_eng.sv
module disk_arb_eng
  import disk_arb_pkg::*;
#(
  parameter int LAT_PIO = 4,
  parameter int LAT_MW  = 3,
  parameter int LAT_UD  = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  cyc_kind_e kind_in,
  output logic      busy,
  output logic      done,
  output cyc_kind_e kind
);
  localparam int MAXL = (LAT_PIO > LAT_MW) ? ((LAT_PIO > LAT_UD) ? LAT_PIO : LAT_UD)
                                           : ((LAT_MW > LAT_UD) ? LAT_MW : LAT_UD);
  localparam int CW = $clog2(MAXL + 1);

  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;
  cyc_kind_e     kind_q, kind_d;
  logic          en;

  function automatic logic [CW-1:0] lat_m1(cyc_kind_e k);
    case (k)
      KIND_PIO: return CW'(LAT_PIO - 1);
      KIND_MW:  return CW'(LAT_MW - 1);
      KIND_UD:  return CW'(LAT_UD - 1);
      default:  return '0;
    endcase
  endfunction

  assign done = busy_q && (cnt_q == '0);
  assign en   = start || busy_q;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    kind_d = kind_q;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = lat_m1(kind_in);
      kind_d = kind_in;
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        busy_d = 1'b0;
        kind_d = KIND_NONE;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      kind_q <= KIND_NONE;
    end else if (en) begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      kind_q <= kind_d;
    end
  end

  assign busy = busy_q;
  assign kind = kind_q;

  // R6
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy_q);
  // R5
  kind_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !done) |=> (busy_q && $stable(kind_q)));
  // R2
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/disk_arb_cnt.sv
module disk_arb_cnt #(
  parameter int CNTW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [CNTW-1:0] load_val,
  input  logic            beat,
  output logic            nonzero,
  output logic            last
);
  logic [CNTW-1:0] rem_q, rem_d;
  logic            en;

  assign en = load || beat;

  always_comb begin
    rem_d = rem_q;
    if (load)      rem_d = load_val;
    else if (beat) rem_d = rem_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rem_q <= '0;
    else if (en) rem_q <= rem_d;
  end

  assign nonzero = (rem_q != '0);
  assign last    = (rem_q == CNTW'(1));

  // R8
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat |-> (rem_q != '0));
  // R10
  count_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !beat) |=> $stable(rem_q));
endmodule

// File: rtl/disk_arb_sel.sv
module disk_arb_sel
  import disk_arb_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      host_req,
  input  logic      dma_en,
  input  logic      drq,
  input  logic      dma_dir,
  input  logic      udma_sel,
  input  logic      buf_full,
  input  logic      buf_empty,
  input  logic      cnt_nonzero,
  input  logic      cnt_last,
  input  logic      eng_busy,
  input  logic      eng_done,
  input  cyc_kind_e eng_kind,
  output logic      start,
  output cyc_kind_e start_kind,
  output logic      host_rdy,
  output logic      beat,
  output logic      buf_push,
  output logic      buf_pop,
  output logic      xfer_done
);
  logic buf_ok, dma_go, dma_cyc;

  assign buf_ok  = dma_dir ? !buf_empty : !buf_full;
  assign dma_go  = dma_en && drq && cnt_nonzero && buf_ok;
  assign start   = !eng_busy && (host_req || dma_go);

  always_comb begin
    if (host_req)      start_kind = KIND_PIO;
    else if (udma_sel) start_kind = KIND_UD;
    else               start_kind = KIND_MW;
  end

  assign dma_cyc   = (eng_kind == KIND_MW) || (eng_kind == KIND_UD);
  assign beat      = eng_done && dma_cyc;
  assign host_rdy  = eng_done && (eng_kind == KIND_PIO);
  assign buf_pop   = beat && dma_dir;
  assign buf_push  = beat && !dma_dir;
  assign xfer_done = beat && cnt_last;

  // R2
  rdy_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_rdy |-> host_req);
  // R3
  buf_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_busy && eng_kind == KIND_PIO) |-> (!buf_push && !buf_pop));
endmodule

// File: rtl/disk_arb_top.sv
module disk_arb_top
  import disk_arb_pkg::*;
#(
  parameter int AW      = 4,
  parameter int DW      = 16,
  parameter int CNTW    = 8,
  parameter int LAT_PIO = 4,
  parameter int LAT_MW  = 3,
  parameter int LAT_UD  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            host_req,
  input  logic            host_we,
  input  logic [AW-1:0]   host_addr,
  input  logic [DW-1:0]   host_wdata,
  output logic            host_rdy,
  output logic [DW-1:0]   host_rdata,
  input  logic            dma_en,
  input  logic            udma_sel,
  input  logic            dma_dir,
  input  logic            drq,
  input  logic            xfer_load,
  input  logic [CNTW-1:0] xfer_len,
  output logic            xfer_done,
  input  logic            buf_full,
  input  logic            buf_empty,
  input  logic [DW-1:0]   buf_rdata,
  output logic            buf_push,
  output logic            buf_pop,
  output logic            disk_cyc,
  output logic [1:0]      disk_kind,
  output logic            disk_we,
  output logic [AW-1:0]   disk_addr,
  output logic [DW-1:0]   disk_wdata,
  input  logic [DW-1:0]   disk_rdata
);
  logic [1:0] rst_sync_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  logic      start, eng_busy, eng_done, beat, cnt_nonzero, cnt_last;
  cyc_kind_e start_kind, eng_kind;
  logic      is_pio;

  disk_arb_eng #(.LAT_PIO(LAT_PIO), .LAT_MW(LAT_MW), .LAT_UD(LAT_UD)) u_eng (
    .clk(clk), .rst_n(rst_s_n), .start(start), .kind_in(start_kind),
    .busy(eng_busy), .done(eng_done), .kind(eng_kind)
  );

  disk_arb_cnt #(.CNTW(CNTW)) u_cnt (
    .clk(clk), .rst_n(rst_s_n), .load(xfer_load), .load_val(xfer_len),
    .beat(beat), .nonzero(cnt_nonzero), .last(cnt_last)
  );

  disk_arb_sel u_sel (
    .clk(clk), .rst_n(rst_s_n), .host_req(host_req), .dma_en(dma_en),
    .drq(drq), .dma_dir(dma_dir), .udma_sel(udma_sel),
    .buf_full(buf_full), .buf_empty(buf_empty),
    .cnt_nonzero(cnt_nonzero), .cnt_last(cnt_last),
    .eng_busy(eng_busy), .eng_done(eng_done), .eng_kind(eng_kind),
    .start(start), .start_kind(start_kind), .host_rdy(host_rdy),
    .beat(beat), .buf_push(buf_push), .buf_pop(buf_pop),
    .xfer_done(xfer_done)
  );

  assign is_pio     = (eng_kind == KIND_PIO);
  assign disk_cyc   = eng_busy;
  assign disk_kind  = eng_kind;
  assign disk_we    = is_pio ? host_we : (eng_busy && dma_dir);
  assign disk_addr  = is_pio ? host_addr : '0;
  assign disk_wdata = is_pio ? host_wdata : buf_rdata;
  assign host_rdata = disk_rdata;

  // R6
  pio_first_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (host_req && !eng_busy) |=> (disk_kind == KIND_PIO));
  // R4
  dma_gate_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    ($rose(disk_cyc) && disk_kind[1]) |-> $past(dma_en && drq));
  // R7
  buf_pause_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    ($rose(disk_cyc) && disk_kind[1]) |-> $past(dma_dir ? !buf_empty : !buf_full));
endmodule

// File: tb/test_disk_arb_top.sv
`timescale 1ns/1ps
module test_disk_arb_top;
  localparam int AW = 4, DW = 16, CNTW = 8;
  localparam int LP = 4, LM = 3, LU = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_req = 0, host_we = 0;
  logic [AW-1:0] host_addr = '0;
  logic [DW-1:0] host_wdata = '0;
  logic host_rdy;
  logic [DW-1:0] host_rdata;
  logic dma_en = 0, udma_sel = 0, dma_dir = 0, drq = 0, xfer_load = 0;
  logic [CNTW-1:0] xfer_len = '0;
  logic xfer_done, buf_full = 0, buf_empty = 0;
  logic [DW-1:0] buf_rdata = 16'h1234;
  logic buf_push, buf_pop, disk_cyc, disk_we;
  logic [1:0] disk_kind;
  logic [AW-1:0] disk_addr;
  logic [DW-1:0] disk_wdata, disk_rdata;

  always #2 clk = ~clk;

  assign disk_rdata = {disk_addr, disk_addr, disk_addr, disk_addr} ^ 16'h5A3C;

  disk_arb_top #(.AW(AW), .DW(DW), .CNTW(CNTW), .LAT_PIO(LP), .LAT_MW(LM), .LAT_UD(LU))
  i_disk_arb_top (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdy(host_rdy),
    .host_rdata(host_rdata), .dma_en(dma_en), .udma_sel(udma_sel),
    .dma_dir(dma_dir), .drq(drq), .xfer_load(xfer_load), .xfer_len(xfer_len),
    .xfer_done(xfer_done), .buf_full(buf_full), .buf_empty(buf_empty),
    .buf_rdata(buf_rdata), .buf_push(buf_push), .buf_pop(buf_pop),
    .disk_cyc(disk_cyc), .disk_kind(disk_kind), .disk_we(disk_we),
    .disk_addr(disk_addr), .disk_wdata(disk_wdata), .disk_rdata(disk_rdata)
  );

  int checks = 0, errors = 0;
  int beats = 0, dones = 0, runs = 0;
  logic [1:0] last_dma_kind = 2'b00;
  logic prev_cyc = 0;
  int run_len = 0;
  logic [1:0] run_kind = 2'b00;
  bit monitor_on = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int lat_of(input logic [1:0] k);
    case (k)
      2'b01: return LP;
      2'b10: return LM;
      2'b11: return LU;
      default: return 0;
    endcase
  endfunction

  // Bus monitor: cycle length per kind, buffer pulse legality
  always @(negedge clk) begin
    if (monitor_on) begin
      if (disk_cyc) begin
        if (!prev_cyc) begin
          run_len = 1; run_kind = disk_kind; runs++;
          if (disk_kind[1]) last_dma_kind = disk_kind;
        end else begin
          run_len++;
          if (disk_kind != run_kind) chk(0, "R5 kind stable", disk_kind, run_kind);
        end
      end else if (prev_cyc) begin
        chk(run_len == lat_of(run_kind), "R5/R6 cycle length", run_len, lat_of(run_kind));
      end
      if (buf_push || buf_pop) begin
        beats++;
        if (!(disk_cyc && disk_kind[1])) chk(0, "R3 buffer pulse outside DMA", 1, 0);
        if (buf_pop != dma_dir) chk(0, "R8 pulse direction", buf_pop, dma_dir);
        if (buf_pop && disk_wdata != buf_rdata) chk(0, "R8 disk_wdata", disk_wdata, buf_rdata);
      end
      if (xfer_done) begin
        dones++;
        if (!(buf_push || buf_pop)) chk(0, "R9 done without beat", 0, 1);
      end
      prev_cyc = disk_cyc;
    end
  end

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
    end
  endtask

  task automatic load(input int n);
    xfer_len = CNTW'(n); xfer_load = 1; tick(); xfer_load = 0;
  endtask

  task automatic wait_dones(input int n, input string tag);
    int t = 0;
    while (dones < n && t < 3000) begin tick(); t++; end
    chk(dones >= n, tag, dones, n);
  endtask

  task automatic wait_beats(input int n);
    int t = 0;
    while (beats < n && t < 3000) begin tick(); t++; end
  endtask

  task automatic pio(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d, output int lat);
    int k = 0;
    host_we = we; host_addr = a; host_wdata = d; host_req = 1;
    while (k < 200) begin
      tick(); k++;
      if (host_rdy) break;
    end
    lat = k;
    chk(host_rdy, "R2 host_rdy seen", host_rdy, 1);
    chk(host_rdata == ({a, a, a, a} ^ 16'h5A3C), "R2 host_rdata", host_rdata, {a, a, a, a} ^ 16'h5A3C);
    chk(disk_kind == 2'b01 && disk_addr == a && disk_we == we && disk_wdata == d,
        "R3 bus mirrors host", {disk_kind, disk_addr}, {2'b01, a});
    chk(!buf_push && !buf_pop, "R3 buffer idle", buf_push | buf_pop, 0);
    tick();
    host_req = 0;
    chk(!host_rdy, "R2 rdy single pulse", host_rdy, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int lat, b, r0;
    tick(3);
    // R1 reset state
    chk(!host_rdy && !disk_cyc && !xfer_done && !buf_push && !buf_pop && disk_kind == 2'b00,
        "R1 outputs in reset", {host_rdy, disk_cyc, xfer_done}, 0);
    rst_n = 1;
    tick(4);
    monitor_on = 1;
    chk(!disk_cyc && disk_kind == 2'b00, "R1 outputs after release", disk_cyc, 0);
    dma_en = 1; drq = 1;
    tick(15);
    chk(runs == 0, "R1 no cycle without count", runs, 0);
    dma_en = 0; drq = 0;

    // R2 R3 PIO sweep over all addresses, both directions
    for (int a = 0; a < 16; a++) begin
      for (int w = 0; w < 2; w++) begin
        pio(w[0], AW'(a), DW'(16'hC000 + a * 37 + w), lat);
        chk(lat == LP, "R2 PIO latency", lat, LP);
        tick();
      end
    end

    // R4 gating
    load(3);
    drq = 1; dma_en = 0; r0 = runs;
    tick(15);
    chk(runs == r0, "R4 no cycle with dma_en low", runs, r0);
    drq = 0; dma_en = 1;
    tick(15);
    chk(runs == r0, "R4 no cycle with drq low", runs, r0);
    drq = 1;
    wait_dones(dones + 1, "R4 transfer completes when enabled");
    tick(8); dma_en = 0; drq = 0;

    // R5 R8 R9 sweep mode x direction x length
    for (int m = 0; m < 2; m++) begin
      for (int d = 0; d < 2; d++) begin
        for (int n = 1; n <= 7; n += 2) begin
          udma_sel = m[0]; dma_dir = d[0];
          load(n);
          beats = 0; dones = 0;
          dma_en = 1; drq = 1;
          wait_dones(1, "R9 xfer_done seen");
          tick(10);
          chk(beats == n, "R8 beat count", beats, n);
          chk(dones == 1, "R9 single done", dones, 1);
          chk(last_dma_kind == (m ? 2'b11 : 2'b10), "R5 DMA kind", last_dma_kind, m ? 3 : 2);
          chk(!disk_cyc, "R9 no cycle after done", disk_cyc, 0);
          dma_en = 0; drq = 0;
        end
      end
    end

    // R7 buffer full pause (disk to buffer)
    udma_sel = 0; dma_dir = 0; buf_full = 1;
    load(4); beats = 0; dones = 0; dma_en = 1; drq = 1;
    tick(12);
    chk(beats == 0 && !disk_cyc, "R7 pause on full", beats, 0);
    buf_full = 0;
    wait_dones(1, "R7 resume after full");
    tick(6);
    chk(beats == 4, "R7 words after full", beats, 4);

    // R7 buffer empty pause mid-transfer (buffer to disk)
    dma_dir = 1; udma_sel = 1;
    load(5); beats = 0; dones = 0;
    wait_beats(2);
    buf_empty = 1;
    tick(LU + 2);
    b = beats;
    tick(12);
    chk(beats == b && b < 5, "R7 pause on empty", beats, b);
    buf_empty = 0;
    wait_dones(1, "R7 resume after empty");
    tick(6);
    chk(beats == 5, "R7 words after empty", beats, 5);

    // R10 drq drop keeps the count
    udma_sel = 0; dma_dir = 1;
    load(6); beats = 0; dones = 0;
    wait_beats(2);
    drq = 0;
    tick(LM + 2);
    b = beats;
    tick(15);
    chk(beats == b && !disk_cyc && dones == 0, "R10 no cycle while drq low", beats, b);
    drq = 1;
    wait_dones(1, "R10 resume after drq");
    tick(6);
    chk(beats == 6, "R10 total words", beats, 6);

    // R6 PIO interrupts a running DMA
    udma_sel = 1; dma_dir = 0;
    load(8); beats = 0; dones = 0;
    wait_beats(2);
    pio(1'b0, 4'h9, 16'h0, lat);
    chk(lat <= LU + 1 + LP && lat >= LP, "R6 PIO latency under DMA", lat, LP);
    wait_dones(1, "R6 DMA resumes");
    tick(6);
    chk(beats == 8, "R6 total words kept", beats, 8);
    dma_en = 0; drq = 0;
    tick(4);

    // R6 simultaneous request: PIO first
    udma_sel = 0; dma_dir = 0;
    load(2); beats = 0; dones = 0;
    host_we = 1; host_addr = 4'h3; host_wdata = 16'hBEEF;
    host_req = 1; dma_en = 1; drq = 1;
    tick();
    chk(disk_kind == 2'b01, "R6 PIO wins tie", disk_kind, 1);
    while (!host_rdy) tick();
    tick(); host_req = 0;
    wait_dones(1, "R6 DMA after tie");
    tick(6);
    chk(beats == 2, "R6 words after tie", beats, 2);
    dma_en = 0; drq = 0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule